// File: doc/BRIEF.md
# Post-Transform Vertex Reuse Cache

This block sits between an index stream and a vertex transform unit. Each incoming 16-bit vertex index is looked up in a small fully associative store of recently shaded results. A hit returns the stored payload at once and the transform unit is not used. A miss sends a request to the transform unit, waits for the shaded payload, places it in the store and forwards it downstream.

The store keeps the payloads of the most recent `DEPTH` insertions. Replacement is strictly first-in first-out on insertion order, and a hit does not refresh an entry. The block handles one vertex at a time, so results leave in the order the indices arrived, and a repeated index cannot be transformed twice.

A per-index `indexed` flag selects bypass mode. In that mode every vertex is transformed and the store is neither read nor written. A start-of-draw pulse empties the store. Two counters record indexed hits and misses, so that the reuse rate can be compared with a model of the window.

Top module: `vtx_reuse_cache`

## Requirements
- R1: `DEPTH` may be 16, 24 or 32. The store holds the payloads of the last `DEPTH` indexed insertions, and the write slot wraps from `DEPTH-1` back to 0.
- R2: An indexed index that matches a held entry is a hit. In the cycle after acceptance, `out_valid_o`=1, `out_hit_o`=1 and `out_data_o` is the payload stored at insertion. No transform request is issued and `hit_cnt_o` rises by one.
- R3: An indexed index that matches no held entry is a miss. In the cycle after acceptance, `xf_req_valid_o`=1 with `xf_req_idx_o` equal to the index. The response payload goes out with `out_hit_o`=0, it is inserted, and `miss_cnt_o` rises by one.
- R4: When `indexed_i`=0 at acceptance, the index always produces a transform request. Its result goes out with `out_hit_o`=0. Nothing is inserted, and both counters keep their values.
- R5: Eviction is FIFO on insertion order, and hits do not refresh an entry. An index is a miss once `DEPTH` newer insertions have occurred, even if it hit in between.
- R6: A one-cycle pulse on `draw_start_i` empties the store. The next lookup of any earlier index is a miss, and insertion restarts at slot 0.
- R7: `idx_ready_o` is high only when no vertex is in flight. Results leave in submission order, and at most one transform request is outstanding.
- R8: While `xf_req_valid_o` or `out_valid_o` waits for its ready input, that output stays high and its payload stays stable.
- R9: An index repeated right after its own miss is a hit on the freshly inserted entry.
- R10: After reset, `idx_ready_o`=1, `xf_req_valid_o`=0, `out_valid_o`=0 and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| draw_start_i | input | 1 | Start of draw; empties the store |
| idx_valid_i | input | 1 | Index valid |
| idx_i | input | 16 | Vertex index |
| indexed_i | input | 1 | 1 = indexed draw (use the cache), 0 = bypass |
| idx_ready_o | output | 1 | Index accepted when high with valid |
| xf_req_valid_o | output | 1 | Transform request valid |
| xf_req_idx_o | output | 16 | Index to transform |
| xf_req_ready_i | input | 1 | Transform unit takes the request |
| xf_rsp_valid_i | input | 1 | Shaded payload valid |
| xf_rsp_data_i | input | DATA_W | Shaded payload |
| out_valid_o | output | 1 | Result valid |
| out_data_o | output | DATA_W | Result payload |
| out_hit_o | output | 1 | Result came from the store |
| out_ready_i | input | 1 | Downstream takes the result |
| hit_cnt_o | output | CNT_W | Indexed hits since reset |
| miss_cnt_o | output | CNT_W | Indexed misses since reset |

## Verification
The hardest case to reach is the difference between FIFO and recency replacement. An entry must hit once, late in its life, and then be evicted by exactly one more insertion. The bench inserts an index, fills the remaining `DEPTH-1` slots, hits the first index, and then adds one more new index. It expects a miss on the next lookup. A reference window in the bench also follows a long pseudo-random index pattern that wraps the non-power-of-two write slot several times, and it checks each outcome and payload.

// File: rtl/vrc_pkg.sv
package vrc_pkg;
  localparam int unsigned IDX_W = 16;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_OUT} vrc_state_e;
endpackage

// File: rtl/vrc_tag_store.sv
module vrc_tag_store
  import vrc_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [IDX_W-1:0]  lk_idx_i,
  output logic              lk_hit_o,
  output logic [DATA_W-1:0] lk_data_o,
  input  logic              ins_en_i,
  input  logic [IDX_W-1:0]  ins_idx_i,
  input  logic [DATA_W-1:0] ins_data_i
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PTR_W-1:0]  wr_q;
  logic [DEPTH-1:0]  vld_q;
  logic [DEPTH-1:0]  match;
  logic [IDX_W-1:0]  tag_q [DEPTH];
  logic [DATA_W-1:0] dat_q [DEPTH];
  logic              wr_go;

  assign wr_go = ins_en_i && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         wr_q <= '0;
    else if (clr_i)      wr_q <= '0;
    else if (wr_go)      wr_q <= (wr_q == PTR_W'(DEPTH-1)) ? '0 : wr_q + 1'b1;
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            vld_q[e] <= 1'b0;
      else if (clr_i)                         vld_q[e] <= 1'b0;
      else if (wr_go && wr_q == PTR_W'(e))    vld_q[e] <= 1'b1;
    end

    always_ff @(posedge clk_i) begin
      if (wr_go && wr_q == PTR_W'(e)) begin
        tag_q[e] <= ins_idx_i;
        dat_q[e] <= ins_data_i;
      end
    end

    assign match[e] = vld_q[e] && (tag_q[e] == lk_idx_i);
  end

  // tags are unique (insert only on miss), so an OR-mux suffices
  always_comb begin
    lk_data_o = '0;
    for (int e = 0; e < DEPTH; e++) begin
      if (match[e]) lk_data_o = lk_data_o | dat_q[e];
    end
  end

  assign lk_hit_o = |match;
endmodule

// File: rtl/vrc_ctrl.sv
module vrc_ctrl
  import vrc_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              draw_start_i,
  input  logic              idx_valid_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              indexed_i,
  output logic              idx_ready_o,
  input  logic              lk_hit_i,
  input  logic [DATA_W-1:0] lk_data_i,
  output logic              ins_en_o,
  output logic [IDX_W-1:0]  ins_idx_o,
  output logic [DATA_W-1:0] ins_data_o,
  output logic              xf_req_valid_o,
  output logic [IDX_W-1:0]  xf_req_idx_o,
  input  logic              xf_req_ready_i,
  input  logic              xf_rsp_valid_i,
  input  logic [DATA_W-1:0] xf_rsp_data_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_hit_o,
  input  logic              out_ready_i,
  output logic              hit_evt_o,
  output logic              miss_evt_o
);
  vrc_state_e        st_q;
  logic [IDX_W-1:0]  idx_q;
  logic              ind_q;
  logic [DATA_W-1:0] out_q;
  logic              hit_q;
  logic              accept, use_hit, rsp_take;

  assign idx_ready_o = (st_q == ST_IDLE);
  assign accept      = idx_valid_i && idx_ready_o;
  // a draw start in the same cycle makes the store look empty
  assign use_hit     = accept && indexed_i && lk_hit_i && !draw_start_i;
  assign rsp_take    = (st_q == ST_WAIT) && xf_rsp_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      ind_q <= 1'b0;
      out_q <= '0;
      hit_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          idx_q <= idx_i;
          ind_q <= indexed_i;
          if (use_hit) begin
            out_q <= lk_data_i;
            hit_q <= 1'b1;
            st_q  <= ST_OUT;
          end else begin
            hit_q <= 1'b0;
            st_q  <= ST_REQ;
          end
        end
        ST_REQ:  if (xf_req_ready_i) st_q <= ST_WAIT;
        ST_WAIT: if (rsp_take) begin
          out_q <= xf_rsp_data_i;
          st_q  <= ST_OUT;
        end
        ST_OUT:  if (out_ready_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign xf_req_valid_o = (st_q == ST_REQ);
  assign xf_req_idx_o   = idx_q;
  assign out_valid_o    = (st_q == ST_OUT);
  assign out_data_o     = out_q;
  assign out_hit_o      = hit_q;
  assign ins_en_o       = rsp_take && ind_q;
  assign ins_idx_o      = idx_q;
  assign ins_data_o     = xf_rsp_data_i;
  assign hit_evt_o      = use_hit;
  assign miss_evt_o     = accept && indexed_i && !use_hit;
endmodule

// File: rtl/vrc_stats.sv
module vrc_stats #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_evt_i,
  input  logic             miss_evt_i,
  output logic [CNT_W-1:0] hit_cnt_o,
  output logic [CNT_W-1:0] miss_cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_cnt_o  <= '0;
      miss_cnt_o <= '0;
    end else begin
      if (hit_evt_i)  hit_cnt_o  <= hit_cnt_o + 1'b1;
      if (miss_evt_i) miss_cnt_o <= miss_cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/vtx_reuse_cache.sv
module vtx_reuse_cache
  import vrc_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              draw_start_i,
  input  logic              idx_valid_i,
  input  logic [15:0]       idx_i,
  input  logic              indexed_i,
  output logic              idx_ready_o,
  output logic              xf_req_valid_o,
  output logic [15:0]       xf_req_idx_o,
  input  logic              xf_req_ready_i,
  input  logic              xf_rsp_valid_i,
  input  logic [DATA_W-1:0] xf_rsp_data_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_hit_o,
  input  logic              out_ready_i,
  output logic [CNT_W-1:0]  hit_cnt_o,
  output logic [CNT_W-1:0]  miss_cnt_o
);
  logic              lk_hit;
  logic [DATA_W-1:0] lk_data;
  logic              ins_en;
  logic [IDX_W-1:0]  ins_idx;
  logic [DATA_W-1:0] ins_data;
  logic              hit_evt, miss_evt;

  vrc_tag_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk_i, .rst_ni,
    .clr_i      (draw_start_i),
    .lk_idx_i   (idx_i),
    .lk_hit_o   (lk_hit),
    .lk_data_o  (lk_data),
    .ins_en_i   (ins_en),
    .ins_idx_i  (ins_idx),
    .ins_data_i (ins_data)
  );

  vrc_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i, .rst_ni, .draw_start_i, .idx_valid_i, .idx_i, .indexed_i, .idx_ready_o,
    .lk_hit_i   (lk_hit),
    .lk_data_i  (lk_data),
    .ins_en_o   (ins_en),
    .ins_idx_o  (ins_idx),
    .ins_data_o (ins_data),
    .xf_req_valid_o, .xf_req_idx_o, .xf_req_ready_i, .xf_rsp_valid_i, .xf_rsp_data_i,
    .out_valid_o, .out_data_o, .out_hit_o, .out_ready_i,
    .hit_evt_o  (hit_evt),
    .miss_evt_o (miss_evt)
  );

  vrc_stats #(.CNT_W(CNT_W)) u_stats (
    .clk_i, .rst_ni,
    .hit_evt_i  (hit_evt),
    .miss_evt_i (miss_evt),
    .hit_cnt_o, .miss_cnt_o
  );
endmodule

// File: rtl/vrc_checks.sv
module vrc_checks #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              draw_start_i,
  input logic              idx_valid_i,
  input logic [15:0]       idx_i,
  input logic              indexed_i,
  input logic              idx_ready_o,
  input logic              lk_hit,
  input logic              xf_req_valid_o,
  input logic [15:0]       xf_req_idx_o,
  input logic              xf_req_ready_i,
  input logic              out_valid_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic              out_hit_o,
  input logic              out_ready_i,
  input logic [CNT_W-1:0]  hit_cnt_o,
  input logic [CNT_W-1:0]  miss_cnt_o
);
  logic acc;
  logic hit_acc;
  assign acc     = idx_valid_i && idx_ready_o;
  assign hit_acc = acc && indexed_i && lk_hit && !draw_start_i;

  AST_SINGLE_FLIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_ready_o |-> !out_valid_o && !xf_req_valid_o); // R7
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xf_req_valid_o && !xf_req_ready_i |=> xf_req_valid_o && $stable(xf_req_idx_o)); // R8
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_hit_o)); // R8
  AST_HIT_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_acc |=> out_valid_o && out_hit_o && !xf_req_valid_o); // R2
  AST_MISS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !hit_acc |=> xf_req_valid_o && xf_req_idx_o == $past(idx_i)); // R3
  AST_BYPASS_NOCNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !indexed_i |=> $stable(hit_cnt_o) && $stable(miss_cnt_o)); // R4
  AST_ONE_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_cnt_o != $past(hit_cnt_o) && miss_cnt_o != $past(miss_cnt_o))); // R7
endmodule

bind vtx_reuse_cache vrc_checks #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .draw_start_i, .idx_valid_i, .idx_i, .indexed_i, .idx_ready_o,
  .lk_hit, .xf_req_valid_o, .xf_req_idx_o, .xf_req_ready_i,
  .out_valid_o, .out_data_o, .out_hit_o, .out_ready_i, .hit_cnt_o, .miss_cnt_o
);

// File: tb/vtx_reuse_cache_tb.sv
module vtx_reuse_cache_tb;
  localparam int DEPTH  = 24;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic draw_start = 1'b0, idx_valid = 1'b0, indexed = 1'b1;
  logic [15:0] idx = '0;
  logic idx_ready, req_valid, req_ready = 1'b0, rsp_valid = 1'b0;
  logic [15:0] req_idx;
  logic [DATA_W-1:0] rsp_data = '0, out_data;
  logic out_valid, out_hit, out_ready = 1'b0;
  logic [CNT_W-1:0] hit_cnt, miss_cnt;

  always #5 clk = ~clk;

  vtx_reuse_cache #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .draw_start_i(draw_start),
    .idx_valid_i(idx_valid), .idx_i(idx), .indexed_i(indexed), .idx_ready_o(idx_ready),
    .xf_req_valid_o(req_valid), .xf_req_idx_o(req_idx), .xf_req_ready_i(req_ready),
    .xf_rsp_valid_i(rsp_valid), .xf_rsp_data_i(rsp_data),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_hit_o(out_hit), .out_ready_i(out_ready),
    .hit_cnt_o(hit_cnt), .miss_cnt_o(miss_cnt)
  );

  int n_chk = 0, n_fail = 0;
  int rsp_no = 0;
  // reference FIFO window
  logic [15:0]       m_tag [DEPTH];
  logic              m_vld [DEPTH];
  logic [DATA_W-1:0] m_dat [DEPTH];
  int m_wp = 0, m_hits = 0, m_miss = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic m_clear();
    for (int e = 0; e < DEPTH; e++) m_vld[e] = 1'b0;
    m_wp = 0;
  endtask

  // returns 1 if outcome was a hit
  task automatic run_vtx(input logic [15:0] v, input logic ind, input bit stall, output bit was_hit);
    bit eh = 0;
    logic [DATA_W-1:0] ed = '0;
    if (ind) for (int e = 0; e < DEPTH; e++)
      if (m_vld[e] && m_tag[e] == v) begin eh = 1; ed = m_dat[e]; end
    @(negedge clk);
    idx_valid = 1'b1; idx = v; indexed = ind;
    while (!idx_ready) @(negedge clk);
    @(negedge clk);
    idx_valid = 1'b0;
    if (eh) begin
      chk(out_valid && !req_valid, "R2 hit next cycle, no request", {out_valid, req_valid}, 2'b10);
    end else begin
      chk(req_valid && req_idx == v, ind ? "R3 miss request" : "R4 bypass request", req_idx, v);
      if (stall) begin
        @(negedge clk);
        chk(req_valid && req_idx == v, "R8 request held", req_idx, v);
      end
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
      chk(!req_valid && !out_valid, "R7 one outstanding", {req_valid, out_valid}, 0);
      @(negedge clk);
      rsp_no++;
      ed = {rsp_no[15:0], v};
      rsp_valid = 1'b1; rsp_data = ed;
      @(negedge clk);
      rsp_valid = 1'b0;
      if (ind) begin
        m_tag[m_wp] = v; m_dat[m_wp] = ed; m_vld[m_wp] = 1'b1;
        m_wp = (m_wp == DEPTH-1) ? 0 : m_wp + 1;
      end
    end
    if (ind) begin if (eh) m_hits++; else m_miss++; end
    chk(out_valid && out_data == ed, eh ? "R2 hit data" : "R3 miss data", out_data, ed);
    chk(out_hit == eh, ind ? "R5 hit flag vs window" : "R4 bypass flag", out_hit, eh);
    if (stall) begin
      @(negedge clk);
      chk(out_valid && out_data == ed, "R8 output held", out_data, ed);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(hit_cnt == CNT_W'(m_hits) && miss_cnt == CNT_W'(m_miss), "R2 R3 counters",
        {hit_cnt[15:0], miss_cnt[15:0]}, {m_hits[15:0], m_miss[15:0]});
    was_hit = eh;
  endtask

  initial begin
    #(10 * 200000);
    n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit h;
    m_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10
    chk(idx_ready && !req_valid && !out_valid && hit_cnt == 0 && miss_cnt == 0,
        "R10 reset state", {idx_ready, req_valid, out_valid}, 3'b100);

    // R1 fill all slots, then every one hits (wraps non-power-of-two depth)
    for (int i = 0; i < DEPTH; i++) run_vtx(16'(i), 1'b1, i[0], h);
    for (int i = 0; i < DEPTH; i++) begin
      run_vtx(16'(i), 1'b1, 1'b0, h);
      chk(h, "R1 full window hits", h, 1);
    end

    // R9 repeat right after own miss
    run_vtx(16'd900, 1'b1, 1'b0, h);
    run_vtx(16'd900, 1'b1, 1'b0, h);
    chk(h, "R9 immediate repeat hit", h, 1);

    // R5 FIFO: hit late in life does not refresh
    m_clear(); draw_start = 1'b1; @(negedge clk); draw_start = 1'b0;
    run_vtx(16'd1000, 1'b1, 1'b0, h);
    for (int i = 1; i < DEPTH; i++) run_vtx(16'(1000 + i), 1'b1, 1'b0, h);
    run_vtx(16'd1000, 1'b1, 1'b0, h);
    chk(h, "R5 oldest still held", h, 1);
    run_vtx(16'd2000, 1'b1, 1'b0, h);
    run_vtx(16'd1000, 1'b1, 1'b0, h);
    chk(!h, "R5 evicted despite hit", h, 0);

    // R4 bypass: no insert, no count
    run_vtx(16'd3000, 1'b0, 1'b1, h);
    run_vtx(16'd3000, 1'b0, 1'b0, h);
    chk(!h, "R4 bypass never hits", h, 0);
    run_vtx(16'd3000, 1'b1, 1'b0, h);
    chk(!h, "R4 bypass inserted nothing", h, 0);

    // R6 draw start empties store
    draw_start = 1'b1; @(negedge clk); draw_start = 1'b0; m_clear();
    run_vtx(16'd3000, 1'b1, 1'b0, h);
    chk(!h, "R6 miss after draw start", h, 0);

    // mixed pattern against the reference window
    for (int k = 0; k < 300; k++) begin
      run_vtx(16'((k * 7 + (k >> 3) * 5) % 41), (k % 29) != 3, (k % 5) == 0, h);
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule